// File: doc/BRIEF.md
# Single-Request DMA Read/Write Engine

This block carries out one memory-to-memory copy at a time on behalf of a channel controller. A request carries a source address, a destination address, a byte count and a completion code. The engine first holds the request in a program stage. It then hands the request to a read side and a write side together, but only once both sides are idle. The read side splits the source range into bursts of four 32-bit words. It issues one read command per burst and pushes the returned words into a 16-word data FIFO. The write side drains that FIFO with four-beat write bursts to the destination. It starts as soon as a whole burst is buffered, so writing overlaps reading.

After the final write beat of a request has been accepted, the engine pulses a completion strobe that carries the request's code. The program stage frees up as soon as its request has been handed on, so the next request can wait there while the current one runs. A request with a byte count of zero is handed on like any other, then completes at once without touching either memory port.

Top module: `xfer_engine`

## Requirements
- R1: After reset `req_ready` is 1 and `rd_cmd_valid`, `wr_valid` and `done_valid` are 0. A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after a request is taken.
- R2: A request leaves the program stage only when both the read side and the write side are idle. No read command of request k appears before the completion of every earlier request has been signalled.
- R3: A request with byte count N (a multiple of 16) yields exactly N/16 read commands, at addresses src, src+16, src+32, … in that order. A command held with `rd_cmd_ready` low keeps `rd_cmd_valid` high and its address unchanged.
- R4: A read command is issued only when the FIFO occupancy plus the words still owed by earlier read commands leaves room for 4 more words in the 16-word FIFO. Each read command returns exactly 4 words on `rd_beat_valid`, in address order, and the FIFO never overflows.
- R5: The first beat of each write burst is presented only when at least 4 words are in the FIFO. On a long transfer, writing begins before the last read command has been issued.
- R6: Write beats form bursts of 4. Beat i of the request goes to dst+4·i and carries the word read from src+4·i. `wr_last` is 1 on the fourth beat of each burst. A stalled beat holds its address and data.
- R7: `done_valid` is high for one cycle, exactly one cycle after the last write beat of a non-empty request is accepted. `done_code` then equals that request's code. Completions follow request order.
- R8: A request with byte count 0 produces no read command and no write beat. When it is taken by an idle engine, `done_valid` with its code appears two cycles after the cycle in which it was taken.
- R9: Once a request has been handed on, `req_ready` returns to 1 while that request is still transferring, so a following request can be taken before the first completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered by the channel controller |
| req_ready | output | 1 | Program stage empty; request taken when both high |
| req_src | input | 32 | Source byte address |
| req_dst | input | 32 | Destination byte address |
| req_bytes | input | 16 | Byte count, multiple of 16 |
| req_code | input | 6 | Completion code returned at the end |
| rd_cmd_valid | output | 1 | Read burst command valid |
| rd_cmd_ready | input | 1 | Source port accepts the command |
| rd_cmd_addr | output | 32 | Base byte address of the read burst |
| rd_beat_valid | input | 1 | One returned read word |
| rd_beat_data | input | 32 | Returned read word |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Destination port accepts the beat |
| wr_addr | output | 32 | Byte address of this write beat |
| wr_data | output | 32 | Data of this write beat |
| wr_last | output | 1 | Final beat of a write burst |
| done_valid | output | 1 | One-cycle completion strobe |
| done_code | output | 6 | Completion code of the finished request |

## Verification
Every result has a fixed latency. A read command or write beat counts as accepted at the clock edge that follows the sample showing valid and ready both high. A completion is due in the sample right after the one that showed the final write beat accepted. A zero-length request taken by an idle engine completes two samples after it was taken, and `req_ready` reads 0 one sample after a take. The bench drives inputs just after the falling edge and samples one time unit later. It keeps a behavioural model made of queues of expected read addresses, write beats and codes, plus a running count of FIFO words and owed words. Each sample compares every handshake, and every completion or missing completion, against that model in the cycle it is due.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    parameter int unsigned DATA_W     = 32;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned LEN_W      = 16;
    parameter int unsigned CODE_W     = 6;
    parameter int unsigned BURST_LEN  = 4;
    parameter int unsigned FIFO_DEPTH = 16;

    localparam int unsigned WORD_BYTES  = DATA_W / 8;
    localparam int unsigned WORD_SHIFT  = $clog2(WORD_BYTES);
    localparam int unsigned BURST_BYTES = BURST_LEN * WORD_BYTES;
    localparam int unsigned BURST_SHIFT = $clog2(BURST_BYTES);
    localparam int unsigned NBURST_W    = LEN_W - BURST_SHIFT;
    localparam int unsigned BEAT_W      = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int unsigned PTR_W       = $clog2(FIFO_DEPTH);
    localparam int unsigned CNT_W       = PTR_W + 1;
    localparam int unsigned USED_W      = CNT_W + 1;

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [DATA_W-1:0]   data_t;
    typedef logic [LEN_W-1:0]    len_t;
    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [NBURST_W-1:0] nburst_t;
    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [BEAT_W-1:0]   beat_t;

    typedef struct packed {
        addr_t src;
        addr_t dst;
        len_t  bytes;
        code_t code;
    } xfer_req_t;

    function automatic nburst_t burst_count(input len_t b);
        return nburst_t'(b >> BURST_SHIFT);
    endfunction
endpackage

// File: rtl/xfer_fifo.sv
module xfer_fifo
    import xfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  data_t push_data,
    input  logic  pop,
    output data_t head,
    output cnt_t  count
);
    data_t             mem [FIFO_DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    cnt_t              cnt_q;

    assign head  = mem[rptr_q];
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + 1'b1;
            if (pop)  rptr_q <= rptr_q + 1'b1;
            cnt_q <= cnt_q + cnt_t'(push) - cnt_t'(pop);
        end
    end

    // R4: a returned word always finds a free entry
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < cnt_t'(FIFO_DEPTH)) || pop);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);
endmodule

// File: rtl/xfer_rd_ctl.sv
module xfer_rd_ctl
    import xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  addr_t   load_src,
    input  nburst_t load_bursts,
    input  logic    space_ok,
    input  logic    cmd_ready,
    input  logic    beat_valid,
    output logic    busy,
    output logic    cmd_valid,
    output addr_t   cmd_addr,
    output cnt_t    owed
);
    logic    busy_q;
    addr_t   addr_q;
    nburst_t left_q;
    cnt_t    owed_q;
    logic    fire;

    assign busy      = busy_q;
    assign cmd_valid = busy_q && space_ok;
    assign cmd_addr  = addr_q;
    assign owed      = owed_q;
    assign fire      = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            left_q <= '0;
            owed_q <= '0;
        end else begin
            if (load) begin
                busy_q <= (load_bursts != '0);
                addr_q <= load_src;
                left_q <= load_bursts;
            end else if (fire) begin
                addr_q <= addr_q + addr_t'(BURST_BYTES);
                left_q <= left_q - 1'b1;
                if (left_q == nburst_t'(1)) busy_q <= 1'b0;
            end
            owed_q <= owed_q + (fire ? cnt_t'(BURST_LEN) : '0) - cnt_t'(beat_valid);
        end
    end

    // R3: an offered command is not withdrawn or altered while stalled
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));
endmodule

// File: rtl/xfer_wr_ctl.sv
module xfer_wr_ctl
    import xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  addr_t   load_dst,
    input  nburst_t load_bursts,
    input  code_t   load_code,
    input  cnt_t    fifo_cnt,
    input  data_t   fifo_head,
    input  logic    wr_ready,
    output logic    busy,
    output logic    wr_valid,
    output addr_t   wr_addr,
    output data_t   wr_data,
    output logic    wr_last,
    output logic    pop,
    output logic    done_valid,
    output code_t   done_code
);
    logic    busy_q, done_q;
    addr_t   base_q;
    nburst_t left_q;
    beat_t   beat_q;
    code_t   code_q;
    logic    burst_end;

    assign busy      = busy_q;
    assign burst_end = (beat_q == beat_t'(BURST_LEN - 1));
    assign wr_valid  = busy_q && ((beat_q != '0) || (fifo_cnt >= cnt_t'(BURST_LEN)));
    assign wr_addr   = base_q + (addr_t'(beat_q) << WORD_SHIFT);
    assign wr_data   = fifo_head;
    assign wr_last   = burst_end;
    assign pop       = wr_valid && wr_ready;
    assign done_valid = done_q;
    assign done_code  = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            base_q <= '0;
            left_q <= '0;
            beat_q <= '0;
            code_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                base_q <= load_dst;
                left_q <= load_bursts;
                beat_q <= '0;
                code_q <= load_code;
                if (load_bursts == '0) done_q <= 1'b1;
                else                   busy_q <= 1'b1;
            end else if (pop) begin
                beat_q <= beat_q + 1'b1;
                if (burst_end) begin
                    base_q <= base_q + addr_t'(BURST_BYTES);
                    left_q <= left_q - 1'b1;
                    if (left_q == nburst_t'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    // R6: a stalled beat keeps its address and data
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R7: completion follows the final beat by one cycle
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        pop && burst_end && (left_q == nburst_t'(1)) |=> done_valid);
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic [CODE_W-1:0] req_code,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic [ADDR_W-1:0] rd_cmd_addr,
    input  logic              rd_beat_valid,
    input  logic [DATA_W-1:0] rd_beat_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              done_valid,
    output logic [CODE_W-1:0] done_code
);
    xfer_req_t prog_q;
    logic      prog_full_q;
    logic      take, move;
    logic      rd_busy, wr_busy, space_ok, pop;
    cnt_t      fifo_cnt, rd_owed;
    data_t     fifo_head;
    logic [USED_W-1:0] used;
    nburst_t   prog_bursts;

    assign req_ready   = !prog_full_q;
    assign take        = req_valid && !prog_full_q;
    assign move        = prog_full_q && !rd_busy && !wr_busy;
    assign prog_bursts = burst_count(prog_q.bytes);
    assign used        = {1'b0, fifo_cnt} + {1'b0, rd_owed};
    assign space_ok    = (used + USED_W'(BURST_LEN)) <= USED_W'(FIFO_DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_full_q <= 1'b0;
            prog_q      <= '0;
        end else if (take) begin
            prog_full_q <= 1'b1;
            prog_q      <= '{src: req_src, dst: req_dst, bytes: req_bytes, code: req_code};
        end else if (move) begin
            prog_full_q <= 1'b0;
        end
    end

    xfer_rd_ctl u_rd (
        .clk(clk), .rst(rst), .load(move), .load_src(prog_q.src),
        .load_bursts(prog_bursts), .space_ok(space_ok), .cmd_ready(rd_cmd_ready),
        .beat_valid(rd_beat_valid), .busy(rd_busy), .cmd_valid(rd_cmd_valid),
        .cmd_addr(rd_cmd_addr), .owed(rd_owed)
    );

    xfer_fifo u_fifo (
        .clk(clk), .rst(rst), .push(rd_beat_valid), .push_data(rd_beat_data),
        .pop(pop), .head(fifo_head), .count(fifo_cnt)
    );

    xfer_wr_ctl u_wr (
        .clk(clk), .rst(rst), .load(move), .load_dst(prog_q.dst),
        .load_bursts(prog_bursts), .load_code(prog_q.code), .fifo_cnt(fifo_cnt),
        .fifo_head(fifo_head), .wr_ready(wr_ready), .busy(wr_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_last(wr_last), .pop(pop), .done_valid(done_valid), .done_code(done_code)
    );

    // R1: a taken request occupies the program stage for the next cycle
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    // R4: every issued read burst has room reserved in the FIFO
    a_r4_room_reserved: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid && rd_cmd_ready |-> used + USED_W'(BURST_LEN) <= USED_W'(FIFO_DEPTH));
endmodule

// File: tb/xfer_engine_test.sv
module xfer_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_src = '0, req_dst = '0;
    logic [15:0] req_bytes = '0;
    logic [5:0]  req_code = '0;
    logic        rd_cmd_valid, rd_cmd_ready = 1'b0;
    logic [31:0] rd_cmd_addr;
    logic        rd_beat_valid = 1'b0;
    logic [31:0] rd_beat_data = '0;
    logic        wr_valid, wr_ready = 1'b0, wr_last;
    logic [31:0] wr_addr, wr_data;
    logic        done_valid;
    logic [5:0]  done_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes), .req_code(req_code),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
        .rd_beat_valid(rd_beat_valid), .rd_beat_data(rd_beat_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_last(wr_last), .done_valid(done_valid), .done_code(done_code)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit timed_out = 0;
    int rd_mode = 0, wr_mode = 0, src_slow = 0;

    // pending requests to offer
    int p_src[$], p_dst[$], p_bytes[$], p_code[$];
    // reference model
    int e_rd_addr[$], e_rd_idx[$];
    int e_wr_addr[$], e_wr_data[$], e_wr_last[$];
    int e_code[$], e_zero[$], e_acc[$];
    int src_beats[$];
    int fifo_words = 0, owed_words = 0, req_idx = 0, done_cnt = 0, beat_in_burst = 0;
    bit exp_done = 0;
    int rd_cmd_total = 0, wr_beat_total = 0;
    int last_acc_cyc = -1, last_done_cyc = -1, first_wr_cyc = -1, last_rd_cyc = -1;

    function automatic int pat(input int a);
        return {a[15:0], a[31:16]} ^ 32'h3C5A_96E1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic offer(input int s, input int d, input int b, input int c);
        p_src.push_back(s); p_dst.push_back(d); p_bytes.push_back(b); p_code.push_back(c);
    endtask

    task automatic step();
        bit hs;
        @(negedge clk);
        cyc++;
        if (cyc > WATCHDOG) timed_out = 1;
        rd_cmd_ready = (rd_mode == 0) || (cyc % (rd_mode + 1) == 0);
        wr_ready     = (wr_mode == 0) || (cyc % (wr_mode + 1) == 0);
        if (src_beats.size() > 0 && (src_slow == 0 || cyc % 3 == 0)) begin
            rd_beat_valid = 1'b1;
            rd_beat_data  = pat(src_beats.pop_front());
        end else begin
            rd_beat_valid = 1'b0;
        end
        if (p_src.size() > 0) begin
            req_valid = 1'b1;
            req_src = p_src[0]; req_dst = p_dst[0];
            req_bytes = 16'(p_bytes[0]); req_code = 6'(p_code[0]);
        end else begin
            req_valid = 1'b0;
        end
        #1;
        // completion due from last cycle's final beat (R7)
        if (exp_done) check(done_valid == 1'b1, "R7 done one cycle after last beat", int'(done_valid), 1);
        if (done_valid) begin
            if (e_code.size() == 0) begin
                check(0, "R7 unexpected completion", int'(done_code), 0);
            end else begin
                check(int'(done_code) == e_code[0], "R7 completion code order", int'(done_code), e_code[0]);
                if (e_zero[0] == 0)
                    check(exp_done, "R7 completion without final beat", 0, 1);
                else
                    check(cyc >= e_acc[0] + 2, "R8 zero completion too early", cyc, e_acc[0] + 2);
                void'(e_code.pop_front()); void'(e_zero.pop_front()); void'(e_acc.pop_front());
                done_cnt++;
                last_done_cyc = cyc;
            end
        end
        exp_done = 0;
        // request handshake
        if (req_valid && req_ready) begin
            int s = p_src.pop_front(), d = p_dst.pop_front();
            int b = p_bytes.pop_front(), c = p_code.pop_front();
            int nb = b / 16;
            for (int i = 0; i < nb; i++) begin
                e_rd_addr.push_back(s + 16 * i); e_rd_idx.push_back(req_idx);
            end
            for (int w = 0; w < 4 * nb; w++) begin
                e_wr_addr.push_back(d + 4 * w); e_wr_data.push_back(pat(s + 4 * w));
                e_wr_last.push_back(w == 4 * nb - 1);
            end
            e_code.push_back(c); e_zero.push_back(nb == 0); e_acc.push_back(cyc);
            req_idx++;
            last_acc_cyc = cyc;
        end
        // write beat (FIFO model still holds pre-edge value)
        hs = wr_valid && wr_ready;
        if (hs) begin
            wr_beat_total++;
            if (first_wr_cyc < 0) first_wr_cyc = cyc;
            if (beat_in_burst == 0) check(fifo_words >= 4, "R5 burst started below threshold", fifo_words, 4);
            check(int'(wr_last) == (beat_in_burst == 3), "R6 wr_last position", int'(wr_last), int'(beat_in_burst == 3));
            if (e_wr_addr.size() == 0) begin
                check(0, "R6 unexpected write beat", wr_addr, 0);
            end else begin
                check(wr_addr == e_wr_addr[0], "R6 write address", wr_addr, e_wr_addr[0]);
                check(wr_data == e_wr_data[0], "R6 write data", wr_data, e_wr_data[0]);
                if (e_wr_last[0] != 0) exp_done = 1;
                void'(e_wr_addr.pop_front()); void'(e_wr_data.pop_front()); void'(e_wr_last.pop_front());
            end
            fifo_words--;
            beat_in_burst = (beat_in_burst + 1) % 4;
        end
        // read command
        if (rd_cmd_valid && rd_cmd_ready) begin
            rd_cmd_total++;
            last_rd_cyc = cyc;
            check(fifo_words + owed_words + 4 <= 16, "R4 read issued without room", fifo_words + owed_words, 12);
            if (e_rd_addr.size() == 0) begin
                check(0, "R3 unexpected read command", rd_cmd_addr, 0);
            end else begin
                check(rd_cmd_addr == e_rd_addr[0], "R3 read address", rd_cmd_addr, e_rd_addr[0]);
                check(done_cnt >= e_rd_idx[0], "R2 read before earlier completion", done_cnt, e_rd_idx[0]);
                void'(e_rd_addr.pop_front()); void'(e_rd_idx.pop_front());
            end
            for (int j = 0; j < 4; j++) src_beats.push_back(rd_cmd_addr + 4 * j);
            owed_words += 4;
        end
        if (rd_beat_valid) begin
            fifo_words++;
            owed_words--;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!timed_out && n < 5000 &&
               (p_src.size() != 0 || e_code.size() != 0 || src_beats.size() != 0)) begin
            step();
            n++;
        end
        repeat (3) step();
    endtask

    initial begin
        int acc, rd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);
        check(rd_cmd_valid == 1'b0, "R1 reset rd_cmd_valid", int'(rd_cmd_valid), 0);
        check(wr_valid == 1'b0, "R1 reset wr_valid", int'(wr_valid), 0);
        check(done_valid == 1'b0, "R1 reset done_valid", int'(done_valid), 0);

        // long transfer, all ports fast: overlap of reads and writes (R5) and early program release (R9)
        offer(32'h0000_1000, 32'h0008_0000, 128, 6'h15);
        step();
        acc = last_acc_cyc;
        check(acc == cyc, "R1 request taken when ready", acc, cyc);
        step();
        check(req_ready == 1'b0, "R1 ready low after take", int'(req_ready), 0);
        step();
        check(req_ready == 1'b1 && e_code.size() == 1, "R9 program stage free while busy",
              int'(req_ready), 1);
        wait_idle();
        check(first_wr_cyc >= 0 && first_wr_cyc < last_rd_cyc, "R5 writes overlap reads",
              first_wr_cyc, last_rd_cyc);
        check(wr_beat_total == 32 && rd_cmd_total == 8, "R3 burst counts",
              rd_cmd_total, 8);

        // zero-length request on an idle engine (R8)
        rd0 = rd_cmd_total;
        acc = wr_beat_total;
        offer(32'h0000_2000, 32'h0009_0000, 0, 6'h2A);
        step();
        step();
        step();
        check(last_done_cyc == last_acc_cyc + 2, "R8 zero completion timing",
              last_done_cyc, last_acc_cyc + 2);
        wait_idle();
        check(rd_cmd_total == rd0 && wr_beat_total == acc, "R8 no traffic for zero length",
              rd_cmd_total - rd0, 0);

        // back-to-back requests with slow writes and slow source (R2, R7)
        wr_mode = 2; src_slow = 1;
        offer(32'h0000_3000, 32'h000A_0000, 64, 6'h01);
        offer(32'h0000_4000, 32'h000B_0000, 32, 6'h02);
        offer(32'h0000_5000, 32'h000C_0000, 0,  6'h03);
        offer(32'h0000_6000, 32'h000D_0000, 16, 6'h04);
        wait_idle();
        check(done_cnt == 6, "R7 all completions seen", done_cnt, 6);

        // stalling read command port, fast writes (R3 hold, R4)
        wr_mode = 0; src_slow = 0; rd_mode = 2;
        offer(32'h0001_0000, 32'h000E_0000, 96, 6'h3F);
        offer(32'h0002_0000, 32'h000F_0000, 48, 6'h00);
        wait_idle();
        check(done_cnt == 8 && e_wr_addr.size() == 0 && e_rd_addr.size() == 0,
              "R6 all traffic drained", done_cnt, 8);

        if (timed_out) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule